// File: doc/BRIEF.md
# Trigger-Sequenced Control Machine with Self-Recovering One-Hot State

This block is a small control sequencer paced by an external trigger wire that has no timing relation to the local clock. The raw trigger is first carried through a chain of synchronizing flip-flops. A registered copy of the synchronized level is then used to find rising edges. Only the synchronized level and the edge pulse reach the next-state logic.

The sequencer has three states, and each state owns one bit of a three-bit register. After reset it passes through its initial state and then waits for a trigger edge. On an edge it enters an armed state and holds there until the trigger drops, and then it goes back to waiting.

Every cycle the register is checked for exactly one set bit. A pattern with no bit set or with several bits set does not stay in the register. On the next edge it is replaced by the initial state, and a one-cycle recovery pulse is raised. A debug load port lets a test write any pattern into the register, including corrupted ones.

Top module: `trig_seq_top`

## Requirements
- R1: While `rst_ni` is low, `state_o` is 3'b001 (initial), `state_ok_o` is 1 and `recover_o` is 0. After `rst_ni` rises, the first clock edge moves `state_o` to 3'b010 (waiting).
- R2: `state_o` bit 0 marks the initial state, bit 1 the waiting state and bit 2 the armed state. `state_ok_o` is 1 exactly when one bit of `state_o` is set.
- R3: `trig_i` reaches the state logic only through SYNC_STAGES flip-flops (default 2). With the default, a raw rise applied between edges while waiting shows as `state_o` = 3'b100 after the third following clock edge, and not before.
- R4: While waiting with the trigger held low, the state stays 3'b010 for any number of cycles.
- R5: In the armed state the machine stays at 3'b100 while the synchronized trigger is high. With the default depth it returns to 3'b010 on the third clock edge after a raw fall.
- R6: A trigger level that stays high with no fresh rising edge never moves the waiting state to the armed state. Each synchronized rising edge causes at most one such move.
- R7: A register value with zero bits or two or more bits set becomes 3'b001 on the next clock edge. It becomes 3'b010 on the edge after that.
- R8: `recover_o` is high for exactly the one cycle in which the initial state appears because of an illegal value. It is low at all other times.
- R9: When `dbg_load_i` is high at a clock edge, the state register takes `dbg_state_i`, overriding recovery and normal transitions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| trig_i | input | 1 | Raw asynchronous trigger |
| dbg_load_i | input | 1 | Debug: load `dbg_state_i` into the state register |
| dbg_state_i | input | 3 | Debug: pattern to load |
| state_o | output | 3 | One-hot state vector |
| state_ok_o | output | 1 | High when exactly one state bit is set |
| recover_o | output | 1 | One-cycle pulse on illegal-state recovery |

## Verification
The transition assertions assume two things. The debug load port is idle on the cycle being checked. Reset has released with the synchronizer and edge register already cleared. The bench therefore drives the trigger only at falling clock edges and holds every level for at least three clock periods, so no edge is lost in the synchronizer. It pulses the debug load for exactly one cycle, with the trigger low, so each recovery is seen without any other input in the way.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;
    localparam int unsigned NUM_STATES = 3;

    typedef enum int unsigned {
        IDX_INIT  = 0,
        IDX_WAIT  = 1,
        IDX_ARMED = 2
    } state_idx_e;

    typedef logic [NUM_STATES-1:0] state_vec_t;

    localparam state_vec_t ST_INIT  = state_vec_t'(1) << IDX_INIT;
    localparam state_vec_t ST_WAIT  = state_vec_t'(1) << IDX_WAIT;
    localparam state_vec_t ST_ARMED = state_vec_t'(1) << IDX_ARMED;

    typedef struct packed {
        state_vec_t state;
        logic       recover;
    } seq_regs_t;
endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);
    localparam int unsigned DEPTH = (STAGES < 2) ? 2 : STAGES;

    logic [DEPTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[DEPTH-2:0], async_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign sync_o = chain_q[DEPTH-1];

    // R3
    sync_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sync_o == $past(chain_q[DEPTH-2]) || $past(!rst_ni));
endmodule

// File: rtl/trig_edge.sv
module trig_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic level_i,
    output logic rise_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = level_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= prev_d;
    end

    assign rise_o = level_i & ~prev_q;

    // R6
    single_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> !rise_o);
endmodule

// File: rtl/trig_seq_fsm.sv
module trig_seq_fsm
    import trig_seq_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       level_i,
    input  logic       rise_i,
    input  logic       dbg_load_i,
    input  state_vec_t dbg_state_i,
    output state_vec_t state_o,
    output logic       state_ok_o,
    output logic       recover_o
);
    seq_regs_t regs_d, regs_q;
    logic      legal;

    assign legal = $onehot(regs_q.state);

    always_comb begin
        regs_d         = regs_q;
        regs_d.recover = 1'b0;
        if (dbg_load_i) begin
            regs_d.state = dbg_state_i;
        end else if (!legal) begin
            regs_d.state   = ST_INIT;
            regs_d.recover = 1'b1;
        end else begin
            unique case (1'b1)
                regs_q.state[IDX_INIT]:  regs_d.state = ST_WAIT;
                regs_q.state[IDX_WAIT]:  if (rise_i)   regs_d.state = ST_ARMED;
                regs_q.state[IDX_ARMED]: if (!level_i) regs_d.state = ST_WAIT;
                default:                 regs_d.state = ST_INIT;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q.state   <= ST_INIT;
            regs_q.recover <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign state_o    = regs_q.state;
    assign state_ok_o = legal;
    assign recover_o  = regs_q.recover;

    // R7
    illegal_to_init_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!state_ok_o && !dbg_load_i) |=> (state_o == ST_INIT));
    // R8
    recover_init_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        recover_o |-> (state_o == ST_INIT && !$past(state_ok_o)));
    // R1
    init_to_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == ST_INIT && !dbg_load_i) |=> (state_o == ST_WAIT));
    // R5
    armed_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == ST_ARMED && level_i && !dbg_load_i) |=> (state_o == ST_ARMED));
    // R6
    wait_no_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == ST_WAIT && !rise_i && !dbg_load_i) |=> (state_o == ST_WAIT));
    // R9
    dbg_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dbg_load_i |=> (state_o == $past(dbg_state_i)));
endmodule

// File: rtl/trig_seq_top.sv
module trig_seq_top
    import trig_seq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  trig_i,
    input  logic                  dbg_load_i,
    input  logic [NUM_STATES-1:0] dbg_state_i,
    output logic [NUM_STATES-1:0] state_o,
    output logic                  state_ok_o,
    output logic                  recover_o
);
    logic trig_level;
    logic trig_rise;

    trig_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (trig_i),
        .sync_o  (trig_level)
    );

    trig_edge edge_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .level_i (trig_level),
        .rise_o  (trig_rise)
    );

    trig_seq_fsm fsm_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .level_i     (trig_level),
        .rise_i      (trig_rise),
        .dbg_load_i  (dbg_load_i),
        .dbg_state_i (dbg_state_i),
        .state_o     (state_o),
        .state_ok_o  (state_ok_o),
        .recover_o   (recover_o)
    );

    // R8
    recover_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        recover_o |=> !recover_o);
endmodule

// File: tb/trig_seq_top_tb_top.sv
module trig_seq_top_tb_top;
    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       trig_i = 1'b0;
    logic       dbg_load_i = 1'b0;
    logic [2:0] dbg_state_i = 3'b000;
    logic [2:0] state_o;
    logic       state_ok_o;
    logic       recover_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [2:0] S_INIT  = 3'b001;
    localparam logic [2:0] S_WAIT  = 3'b010;
    localparam logic [2:0] S_ARMED = 3'b100;

    always #5 clk_i = ~clk_i;

    trig_seq_top dut_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .trig_i      (trig_i),
        .dbg_load_i  (dbg_load_i),
        .dbg_state_i (dbg_state_i),
        .state_o     (state_o),
        .state_ok_o  (state_ok_o),
        .recover_o   (recover_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_state(input string req, input logic [2:0] exp);
        check(state_o === exp, req, {29'd0, state_o}, {29'd0, exp});
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk_i);
        @(negedge clk_i);
    endtask

    task automatic t_reset();
        @(negedge clk_i);
        rst_ni = 1'b0;
        step(3);
        check_state("R1 reset state", S_INIT);
        check(state_ok_o === 1'b1, "R1 ok during reset", {31'd0, state_ok_o}, 1);
        check(recover_o === 1'b0, "R1 recover during reset", {31'd0, recover_o}, 0);
        rst_ni = 1'b1;
        step(1);
        check_state("R1 wait after release", S_WAIT);
        check(state_ok_o === 1'b1, "R2 ok in wait", {31'd0, state_ok_o}, 1);
    endtask

    task automatic t_idle(input int n);
        step(n);
        check_state("R4 idle wait", S_WAIT);
        check(recover_o === 1'b0, "R8 no recover idle", {31'd0, recover_o}, 0);
    endtask

    task automatic t_trigger(input int hold);
        trig_i = 1'b1;
        step(2);
        check_state("R3 not yet armed after two edges", S_WAIT);
        step(1);
        check_state("R3 armed on third edge", S_ARMED);
        check(state_ok_o === 1'b1, "R2 ok in armed", {31'd0, state_ok_o}, 1);
        step(hold);
        check_state("R5 armed held", S_ARMED);
        trig_i = 1'b0;
        step(2);
        check_state("R5 still armed after two edges", S_ARMED);
        step(1);
        check_state("R5 back to wait", S_WAIT);
        check(recover_o === 1'b0, "R8 no recover in normal run", {31'd0, recover_o}, 0);
    endtask

    task automatic t_level_no_edge();
        trig_i = 1'b1;
        step(4);
        check_state("R6 armed on edge", S_ARMED);
        dbg_load_i  = 1'b1;
        dbg_state_i = S_WAIT;
        step(1);
        dbg_load_i = 1'b0;
        check_state("R9 loaded wait", S_WAIT);
        step(8);
        check_state("R6 high level without edge stays wait", S_WAIT);
        trig_i = 1'b0;
        step(5);
        check_state("R6 wait after fall", S_WAIT);
    endtask

    task automatic t_corrupt(input logic [2:0] bad);
        dbg_load_i  = 1'b1;
        dbg_state_i = bad;
        step(1);
        dbg_load_i = 1'b0;
        check_state("R9 corrupt value loaded", bad);
        check(state_ok_o === 1'b0, "R2 ok low on illegal", {31'd0, state_ok_o}, 0);
        check(recover_o === 1'b0, "R8 recover low before fix", {31'd0, recover_o}, 0);
        step(1);
        check_state("R7 forced to init", S_INIT);
        check(recover_o === 1'b1, "R8 recover pulse", {31'd0, recover_o}, 1);
        step(1);
        check_state("R7 init then wait", S_WAIT);
        check(recover_o === 1'b0, "R8 recover single cycle", {31'd0, recover_o}, 0);
    endtask

    initial begin
        t_reset();
        t_idle(50);
        t_trigger(3);
        t_trigger(7);
        t_trigger(20);
        t_level_no_edge();
        t_corrupt(3'b000);
        t_corrupt(3'b011);
        t_corrupt(3'b110);
        t_corrupt(3'b101);
        t_corrupt(3'b111);
        t_trigger(4);
        t_idle(10);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk_i);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule